// File: doc/BRIEF.md
# Instruction Dispatch Controller

This block sequences a control unit that feeds a single downstream execution unit. It fetches 40-bit instruction words from a synchronous memory port and decodes each one into one of four classes: a unit command, an internal control step, an unconditional jump or a halt. Index arithmetic sits outside the block, which presents the index selector and the address field and takes back a combinational sum.

The controller does not wait for the execution unit. It keeps fetching, indexing and reading operands while the unit is busy. The next command and its operand wait in an outgoing slot, which is offered to the unit as soon as the unit reports completion. A second command that finds the slot full stays in the instruction register, which now serves as operand storage, and fetch stops until the slot drains. Completion is signalled one cycle ahead of the unit's own ready, so the next command is already on the outputs when the unit can take it.

Instruction word layout: bits 39:38 give the class (00 unit command, 01 control, 10 jump, 11 halt). Bits 39:32 are the command byte that goes to the unit. Bit 23 selects the jump source (1 = operand address register, 0 = address field). Bits 22:20 are the index selector and bits 19:0 are the address field.

Top module: `instr_dispatch`

## Requirements
- R1: While reset is held, the block requests a fetch from address 0, dispatch valid is low and halted is low.
- R2: Sequential instructions are fetched from consecutive addresses. The fetch address steps by one after each instruction word is loaded.
- R3: A unit command (class 00) reads its operand from the low 16 bits of the index sum. The unit then receives the command byte (bits 39:32) together with that 40-bit operand.
- R4: A control instruction (class 01) loads the 20-bit operand address register from the index sum. It causes no dispatch.
- R5: A jump (class 10) fetches its target in the same cycle it is decoded. The target is the low 16 bits of the operand address register when bit 23 is 1, and bits 15:0 of the word when bit 23 is 0. The word after the jump is never executed.
- R6: A halt (class 11) stops all fetching. Halted stays high until reset.
- R7: While dispatch valid is high and ready is low, valid, command and operand hold their values.
- R8: Decode and operand fetch go on while the unit is busy. A decoded command is placed in the outgoing slot even though the unit cannot take it yet.
- R9: Only one command waits in the outgoing slot. A second decoded unit command stops fetch until the slot hands off. At the hand-off edge the waiting command moves into the slot and fetch resumes.
- R10: After a hand-off the unit counts as busy and dispatch valid stays low. Valid rises in the cycle after the end-of-command input is seen high, provided a command is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memRd | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memRdata | input | 40 | Read data, valid the cycle after the request |
| idxSel | output | 3 | Index register selector for the external adder |
| idxField | output | 20 | Address field for the external adder |
| idxResult | input | 20 | Combinational index sum |
| dispValid | output | 1 | Command offered to the unit |
| dispCmd | output | 8 | Command byte |
| dispOperand | output | 40 | Operand word |
| dispReady | input | 1 | Unit accepts the command |
| unitEoc | input | 1 | Early end-of-command from the unit |
| halted | output | 1 | Halt reached |

## Verification
A fetch request goes out combinationally in the fetch state. The word arrives one edge later and is decoded on the next edge. The first unit command therefore appears in the slot four edges after reset is released. A hand-off changes valid and the slot contents at the same edge, and an end-of-command pulse raises valid at the edge that samples it. The bench drives every input at the falling edge and reads the outputs at a later falling edge, after counting the rising edges given above. Hand-offs are logged at the falling edge before the accepting rising edge, so each logged command is compared against an ordered expected list.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int WORD_W = 40;
  localparam int PC_W   = 16;
  localparam int IDX_W  = 20;
  localparam int CMD_W  = 8;
  localparam int SEL_W  = 3;
  localparam int CLS_HI = WORD_W - 1;
  localparam int CMD_LO = WORD_W - CMD_W;
  localparam int SRC_BIT = IDX_W + SEL_W;

  typedef enum logic [1:0] {
    CLS_UNIT = 2'b00,
    CLS_CTRL = 2'b01,
    CLS_JUMP = 2'b10,
    CLS_HALT = 2'b11
  } opclass_t;

  typedef enum logic [1:0] {
    ADDR_PC  = 2'd0,
    ADDR_IDX = 2'd1,
    ADDR_JMP = 2'd2
  } addrsel_t;

  typedef struct packed {
    logic     memRd;
    addrsel_t addrSel;
    logic     loadIr;
    logic     incPc;
    logic     jumpPc;
    logic     loadOar;
    logic     saveCmd;
    logic     fillFromMem;
    logic     fillFromIr;
  } strobes_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  opclass_t opClass,
  input  logic     slotFree,
  output strobes_t st,
  output logic     halted
);
  typedef enum logic [2:0] {
    ST_FETCH, ST_LOAD, ST_EXEC, ST_OPLOAD, ST_PARK, ST_HALT
  } state_t;

  state_t state, nxt;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      ST_FETCH: begin
        st.memRd   = 1'b1;
        st.addrSel = ADDR_PC;
        nxt        = ST_LOAD;
      end
      ST_LOAD: begin
        st.loadIr = 1'b1;
        st.incPc  = 1'b1;
        nxt       = ST_EXEC;
      end
      ST_EXEC: begin
        case (opClass)
          CLS_UNIT: begin
            st.memRd   = 1'b1;
            st.addrSel = ADDR_IDX;
            st.loadOar = 1'b1;
            st.saveCmd = 1'b1;
            nxt        = ST_OPLOAD;
          end
          CLS_CTRL: begin
            st.loadOar = 1'b1;
            nxt        = ST_FETCH;
          end
          CLS_JUMP: begin
            st.memRd   = 1'b1;
            st.addrSel = ADDR_JMP;
            st.jumpPc  = 1'b1;
            nxt        = ST_LOAD;
          end
          default: nxt = ST_HALT;
        endcase
      end
      ST_OPLOAD: begin
        st.loadIr = 1'b1;
        if (slotFree) begin
          st.fillFromMem = 1'b1;
          nxt            = ST_FETCH;
        end else begin
          nxt = ST_PARK;
        end
      end
      ST_PARK: begin
        if (slotFree) begin
          st.fillFromIr = 1'b1;
          nxt           = ST_FETCH;
        end
      end
      default: nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_FETCH;
    else       state <= nxt;
  end

  assign halted = (state == ST_HALT);

  // R6: once halted, stays halted and never fetches again
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !st.memRd);

  // R9: a parked command keeps fetch stopped until the slot frees
  a_r9_park_stall: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARK && !slotFree) |=> !st.memRd);
endmodule

// File: rtl/dispatch_path.sv
module dispatch_path
  import dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [WORD_W-1:0]  memRdata,
  input  logic [IDX_W-1:0]   idxResult,
  input  logic               dispReady,
  input  logic               unitEoc,
  output logic [PC_W-1:0]    memAddr,
  output logic [SEL_W-1:0]   idxSel,
  output logic [IDX_W-1:0]   idxField,
  output opclass_t           opClass,
  output logic               slotFree,
  output logic               dispValid,
  output logic [CMD_W-1:0]   dispCmd,
  output logic [WORD_W-1:0]  dispOperand
);
  logic [WORD_W-1:0] ir;
  logic [CMD_W-1:0]  saveReg;
  logic [PC_W-1:0]   pc;
  logic [IDX_W-1:0]  oar;
  logic              slotFull, unitBusy, handoff;
  logic [PC_W-1:0]   jumpTarget;

  assign opClass    = opclass_t'(ir[CLS_HI -: 2]);
  assign idxSel     = ir[SRC_BIT-1 -: SEL_W];
  assign idxField   = ir[IDX_W-1:0];
  assign jumpTarget = ir[SRC_BIT] ? oar[PC_W-1:0] : ir[PC_W-1:0];
  assign dispValid  = slotFull && !unitBusy;
  assign handoff    = dispValid && dispReady;
  assign slotFree   = !slotFull || handoff;

  always_comb begin
    case (st.addrSel)
      ADDR_IDX: memAddr = idxResult[PC_W-1:0];
      ADDR_JMP: memAddr = jumpTarget;
      default:  memAddr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ir      <= '0;
      saveReg <= '0;
      pc      <= '0;
      oar     <= '0;
    end else begin
      if (st.loadIr)  ir      <= memRdata;
      if (st.saveCmd) saveReg <= ir[CLS_HI -: CMD_W];
      if (st.loadOar) oar     <= idxResult;
      if (st.jumpPc)      pc <= jumpTarget;
      else if (st.incPc)  pc <= pc + PC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFull    <= 1'b0;
      unitBusy    <= 1'b0;
      dispCmd     <= '0;
      dispOperand <= '0;
    end else begin
      if (st.fillFromMem) begin
        slotFull    <= 1'b1;
        dispCmd     <= saveReg;
        dispOperand <= memRdata;
      end else if (st.fillFromIr) begin
        slotFull    <= 1'b1;
        dispCmd     <= saveReg;
        dispOperand <= ir;
      end else if (handoff) begin
        slotFull <= 1'b0;
      end
      if (handoff)      unitBusy <= 1'b1;
      else if (unitEoc) unitBusy <= 1'b0;
    end
  end

  // R7: offered command is held until accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispReady) |=> dispValid && $stable(dispCmd) && $stable(dispOperand));

  // R10: unit is busy right after a hand-off
  a_r10_busy_after_handoff: assert property (@(posedge clk) disable iff (!rstN)
    handoff |=> !dispValid);

  // R10: end-of-command releases a waiting command
  a_r10_eoc_release: assert property (@(posedge clk) disable iff (!rstN)
    (unitBusy && unitEoc && (slotFull || st.fillFromMem || st.fillFromIr)) |=> dispValid);

  // R9: the slot is only refilled when it is free
  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rstN)
    (st.fillFromMem || st.fillFromIr) |-> slotFree);

  // R2: sequential step of the instruction counter
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    (st.incPc && !st.jumpPc) |=> pc == $past(pc) + PC_W'(1));

  // R5: jump loads its resolved target
  a_r5_jump_load: assert property (@(posedge clk) disable iff (!rstN)
    st.jumpPc |=> pc == $past(memAddr));
endmodule

// File: rtl/instr_dispatch.sv
module instr_dispatch
  import dispatch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  output logic               memRd,
  output logic [PC_W-1:0]    memAddr,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [SEL_W-1:0]   idxSel,
  output logic [IDX_W-1:0]   idxField,
  input  logic [IDX_W-1:0]   idxResult,
  output logic               dispValid,
  output logic [CMD_W-1:0]   dispCmd,
  output logic [WORD_W-1:0]  dispOperand,
  input  logic               dispReady,
  input  logic               unitEoc,
  output logic               halted
);
  strobes_t st;
  opclass_t opClass;
  logic     slotFree;

  dispatch_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opClass  (opClass),
    .slotFree (slotFree),
    .st       (st),
    .halted   (halted)
  );

  dispatch_path u_path (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .memRdata    (memRdata),
    .idxResult   (idxResult),
    .dispReady   (dispReady),
    .unitEoc     (unitEoc),
    .memAddr     (memAddr),
    .idxSel      (idxSel),
    .idxField    (idxField),
    .opClass     (opClass),
    .slotFree    (slotFree),
    .dispValid   (dispValid),
    .dispCmd     (dispCmd),
    .dispOperand (dispOperand)
  );

  assign memRd = st.memRd;
endmodule

// File: tb/instr_dispatch_test.sv
module instr_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEXP = 4;
  localparam logic [47:0] EXP [NEXP] = '{
    {8'h05, 40'h11_2233_4455},
    {8'h0A, 40'hAA_BBCC_DDEE},
    {8'h11, 40'h01_0203_0405},
    {8'h12, 40'hF0_F0F0_F0F0}
  };

  logic clk = 1'b0;
  logic rstN;
  logic memRd;
  logic [15:0] memAddr;
  logic [39:0] memRdata;
  logic [2:0]  idxSel;
  logic [19:0] idxField, idxResult;
  logic dispValid, dispReady, unitEoc, halted;
  logic [7:0]  dispCmd;
  logic [39:0] dispOperand;

  logic autoUnit, manReady, manEoc, autoEoc;
  logic [39:0] mem [64];
  logic [7:0]  hsCmd [8];
  logic [39:0] hsOp  [8];
  int hsCount;
  logic [2:0] busyCnt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign idxResult = idxField + {13'b0, idxSel, 4'b0};
  assign dispReady = autoUnit ? 1'b1 : manReady;
  assign unitEoc   = autoUnit ? autoEoc : manEoc;

  always @(posedge clk) if (memRd) memRdata <= mem[memAddr[5:0]];

  instr_dispatch uut (
    .clk(clk), .rstN(rstN), .memRd(memRd), .memAddr(memAddr), .memRdata(memRdata),
    .idxSel(idxSel), .idxField(idxField), .idxResult(idxResult),
    .dispValid(dispValid), .dispCmd(dispCmd), .dispOperand(dispOperand),
    .dispReady(dispReady), .unitEoc(unitEoc), .halted(halted)
  );

  // unit model and hand-off log
  always @(negedge clk) begin
    if (!rstN) begin
      hsCount <= 0;
      busyCnt <= '0;
      autoEoc <= 1'b0;
    end else begin
      autoEoc <= 1'b0;
      if (dispValid && dispReady) begin
        if (hsCount < 8) begin
          hsCmd[hsCount[2:0]] <= dispCmd;
          hsOp[hsCount[2:0]]  <= dispOperand;
        end
        hsCount <= hsCount + 1;
        busyCnt <= 3'd4;
      end else if (busyCnt != 0) begin
        busyCnt <= busyCnt - 3'd1;
        if (busyCnt == 3'd1) autoEoc <= 1'b1;
      end
    end
  end

  function automatic logic [39:0] mkInst(input logic [7:0] cmd, input logic src,
                                         input logic [2:0] sel, input logic [19:0] fld);
    return {cmd, 8'h00, src, sel, fld};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL R6 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0]  = mkInst(8'h05, 1'b0, 3'd0, 20'h20);
    mem[1]  = mkInst(8'h0A, 1'b0, 3'd1, 20'h11);
    mem[2]  = mkInst(8'h40, 1'b0, 3'd2, 20'h04);
    mem[3]  = mkInst(8'h80, 1'b1, 3'd0, 20'h00);
    mem[36] = mkInst(8'h11, 1'b0, 3'd0, 20'h22);
    mem[37] = mkInst(8'h80, 1'b0, 3'd0, 20'd40);
    mem[38] = mkInst(8'h3F, 1'b0, 3'd0, 20'h20);
    mem[40] = mkInst(8'h12, 1'b0, 3'd0, 20'h23);
    mem[41] = mkInst(8'hC0, 1'b0, 3'd0, 20'h00);
    mem[6'h20] = 40'h11_2233_4455;
    mem[6'h21] = 40'hAA_BBCC_DDEE;
    mem[6'h22] = 40'h01_0203_0405;
    mem[6'h23] = 40'hF0_F0F0_F0F0;

    // directed run: unit driven by hand
    autoUnit = 1'b0; manReady = 1'b0; manEoc = 1'b0; rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(memRd && memAddr == 16'd0, "R1 fetch addr", {31'b0, memRd, memAddr}, {31'b0, 1'b1, 16'd0});
    chk(!dispValid, "R1 valid", {47'b0, dispValid}, 48'd0);
    chk(!halted, "R1 halted", {47'b0, halted}, 48'd0);
    rstN = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(memRd && memAddr == 16'd1, "R2 next fetch", {31'b0, memRd, memAddr}, {31'b0, 1'b1, 16'd1});
    chk(dispValid && dispCmd == 8'h05, "R3 first cmd", {39'b0, dispValid, dispCmd}, {39'b0, 1'b1, 8'h05});
    repeat (26) @(negedge clk);
    chk(dispValid && dispCmd == 8'h05, "R7 held cmd", {39'b0, dispValid, dispCmd}, {39'b0, 1'b1, 8'h05});
    chk(dispOperand == 40'h11_2233_4455, "R3 operand", {8'b0, dispOperand}, {8'b0, 40'h11_2233_4455});
    chk(!memRd, "R9 fetch stalled", {47'b0, memRd}, 48'd0);
    manReady = 1'b1;
    @(negedge clk);
    manReady = 1'b0;
    chk(!dispValid, "R10 busy after handoff", {47'b0, dispValid}, 48'd0);
    chk({dispCmd, dispOperand} == EXP[1], "R9 parked moved to slot", {dispCmd, dispOperand}, EXP[1]);
    chk(memRd && memAddr == 16'd2, "R9 fetch resumed", {31'b0, memRd, memAddr}, {31'b0, 1'b1, 16'd2});
    repeat (5) @(negedge clk);
    chk(!dispValid && dispCmd == 8'h0A, "R8 slot kept while busy", {39'b0, dispValid, dispCmd}, {39'b0, 1'b0, 8'h0A});
    manEoc = 1'b1;
    @(negedge clk);
    manEoc = 1'b0;
    chk(dispValid && dispCmd == 8'h0A, "R10 valid after eoc", {39'b0, dispValid, dispCmd}, {39'b0, 1'b1, 8'h0A});

    // program run: unit modelled automatically
    rstN = 1'b0;
    autoUnit = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (halted && hsCount >= NEXP) break;
    end
    repeat (20) @(negedge clk);
    chk(hsCount == NEXP, "R4 R5 dispatch count", 48'(hsCount), 48'(NEXP));
    for (int i = 0; i < NEXP; i++)
      chk({hsCmd[i], hsOp[i]} == EXP[i], "R3 R5 R8 dispatch order", {hsCmd[i], hsOp[i]}, EXP[i]);
    chk(halted && !memRd, "R6 halted no fetch", {46'b0, halted, memRd}, {46'b0, 2'b10});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule